// File: doc/BRIEF.md
# Sixteen-Bit Event Timer with Prescaler

This block is a 16-bit up-counter that sits behind an 8-bit register bus. It counts either ticks of an internal cycle clock, which is the system clock divided by a fixed ratio, or rising edges of an external count input. Each count source passes through a divide-by-1/2/4/8 prescaler before it reaches the counter. The external input can pass through a two-flop synchronizer, or it can bypass that stage for lower latency. A run bit gates counting. A sticky flag, also driven onto an interrupt output, records every wrap from all-ones to zero. A one-cycle pulse from a compare unit clears the counter.

Software reaches the count as two byte registers. In wide mode, the high byte at the bus is a holding register, so two 8-bit accesses see a consistent 16-bit value. Reading the low byte latches the live high byte into the holding register. Writing the low byte loads the holding register and the new low byte into the counter in the same cycle. In narrow mode, each byte address reaches the live half of the counter directly.

Top module: `tmr16_unit`

## Requirements
- R1: After reset, the counter, the control register (address 2) and the overflow flag (address 3, bit 0) all read zero, and narrow mode is active.
- R2: With control bit 1 clear and run (bit 0) set, the count source is one tick every INSTR_DIV system clocks. A low-byte write to the counter restarts this phase, so the first tick reaches the counter INSTR_DIV clocks after that write.
- R3: Control bits 5:4 select a prescaler ratio of 2^sel. The counter advances once for every 2^sel source events, on the last event of each group.
- R4: With bit 1 set and bit 2 clear, each rising edge of the external input advances the source through a two-flop synchronizer. The counter changes on the third clock edge at which the input is sampled high.
- R5: With bits 1 and 2 both set, the synchronizer is bypassed. The counter changes on the first clock edge after the external input rises.
- R6: While run is clear, the count and the prescaler hold.
- R7: A wrap from 0xFFFF to 0x0000 sets the flag, which also drives the interrupt output. The flag stays set until a write to address 3 with bit 0 set. A write there with bit 0 clear leaves it set.
- R8: A compare-event pulse clears the counter to zero. It takes priority over a bus write and over an increment in the same cycle, and it never sets the flag.
- R9: In wide mode (bit 7 set), reading address 0 returns the live low byte and latches the live high byte into the holding register. Address 1 then returns the holding register, not the live high byte.
- R10: In wide mode, a write to address 1 changes only the holding register. A write to address 0 loads {holding register, data} into the counter.
- R11: In narrow mode, addresses 0 and 1 read and write the live low and high counter bytes, and each write takes effect at once.
- R12: Every write that changes the counter also empties the prescaler, so the next full group of 2^sel events is needed before the counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 count low, 1 count high, 2 control, 3 flag |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| ext_tick_in | input | 1 | External count input |
| cmp_event | input | 1 | Clear pulse from the compare unit |
| ovf_irq | output | 1 | Overflow flag level |

## Verification
The bench builds the block with INSTR_DIV of 4 and SYNC_STAGES of 2. With a cycle divider of 4, every prescaler ratio up to 8 produces several counts within about a hundred clocks, and a wrap from 0xFFFE takes only eight clocks to reach. With two synchronizer stages, the synchronized and bypassed external paths differ by exactly two clock edges, so a single-cycle read can tell them apart. It also lets a compare pulse be placed on the exact edge where an increment would wrap the counter.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int PS_W   = 2;

  localparam logic [ADDR_W-1:0] ADR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd3;

  // control register bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_SRC  = 1;
  localparam int CB_RAW  = 2;
  localparam int CB_PS   = 4;
  localparam int CB_WIDE = 7;

  typedef struct packed {
    logic            wide;
    logic [PS_W-1:0] ps;
    logic            raw;
    logic            src_ext;
    logic            run;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [BUS_W-1:0] b);
    ctrl_t c;
    c.run     = b[CB_RUN];
    c.src_ext = b[CB_SRC];
    c.raw     = b[CB_RAW];
    c.ps      = b[CB_PS +: PS_W];
    c.wide    = b[CB_WIDE];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
    logic [BUS_W-1:0] b;
    b                 = '0;
    b[CB_RUN]         = c.run;
    b[CB_SRC]         = c.src_ext;
    b[CB_RAW]         = c.raw;
    b[CB_PS +: PS_W]  = c.ps;
    b[CB_WIDE]        = c.wide;
    return b;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic bypass,
  output logic edge_pulse
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES:0]   chain_in;
  logic              sync_prev_q;
  logic              raw_prev_q;
  logic              sync_edge;
  logic              raw_edge;

  assign chain_in = {chain_q, ext_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q     <= '0;
      sync_prev_q <= 1'b0;
      raw_prev_q  <= 1'b0;
    end else begin
      chain_q     <= chain_in[STAGES-1:0];
      sync_prev_q <= chain_q[STAGES-1];
      raw_prev_q  <= ext_in;
    end
  end

  assign sync_edge  = chain_q[STAGES-1] & ~sync_prev_q;
  assign raw_edge   = ext_in & ~raw_prev_q;
  assign edge_pulse = bypass ? raw_edge : sync_edge;

  // R4: a synchronized edge is one cycle wide and traces back to the input STAGES edges earlier
  p_sync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> !sync_edge);
  p_sync_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |-> $past(ext_in, STAGES));

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_pulse,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic             out_pulse
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  function automatic logic [DIV_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
    logic [DIV_W:0] t;
    t = '0;
    t[0] = 1'b1;
    t = t << s;
    t = t - {{DIV_W{1'b0}}, 1'b1};
    return t[DIV_W-1:0];
  endfunction

  assign mask = sel_mask(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (clr)      div_q <= '0;
    else if (in_pulse) div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  assign out_pulse = in_pulse & ~clr & ((div_q & mask) == mask);

  // R3: the prescaler never emits a step without a source event
  p_out_needs_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> in_pulse);
  // R12: a clear empties the group count
  p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> div_q == '0);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic [1:0]   ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count,
  output logic         wrap
);

  localparam int H = W / 2;

  function automatic logic [W-1:0] count_next(input logic [W-1:0] cur, input logic step,
                                             input logic [1:0] ld, input logic [W-1:0] val);
    logic [W-1:0] n;
    n = cur;
    if (ld[0]) n[H-1:0] = val[H-1:0];
    if (ld[1]) n[W-1:H] = val[W-1:H];
    if (ld == 2'b00 && step) n = cur + W'(1);
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count_next(count, inc, ld_en, ld_val);
  end

  assign wrap = inc & ~clr & (ld_en == 2'b00) & (&count);

  // R8: the compare event wins over everything and never wraps
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  p_no_wrap_on_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !wrap);
  // R2: an unopposed step adds exactly one
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && ld_en == 2'b00) |=> count == $past(count) + W'(1));

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr_pkg::*;
#(
  parameter int INSTR_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_tick_in,
  input  logic              cmp_event,
  output logic              ovf_irq
);

  localparam int CNT_W = 2 * BUS_W;
  localparam int DIV_W = (INSTR_DIV > 2) ? $clog2(INSTR_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INSTR_DIV - 1);

  ctrl_t             ctrl_q;
  logic [BUS_W-1:0]  hi_buf;
  logic              ovf_flag;
  logic [DIV_W-1:0]  cyc_q;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  ld_val;
  logic [1:0]        ld_en;

  // named internal events
  logic wr_lo, wr_hi, wr_ctrl, rd_lo, stat_clr;
  logic cnt_write, instr_tick, ext_edge, src_pulse, gated_pulse, step, wrap;

  assign wr_lo    = bus_wr & (bus_addr == ADR_LO);
  assign wr_hi    = bus_wr & (bus_addr == ADR_HI);
  assign wr_ctrl  = bus_wr & (bus_addr == ADR_CTRL);
  assign stat_clr = bus_wr & (bus_addr == ADR_STAT) & bus_wdata[0];
  assign rd_lo    = bus_rd & (bus_addr == ADR_LO);

  // load path: wide mode takes the high half from the holding register
  assign ld_en     = {ctrl_q.wide ? wr_lo : wr_hi, wr_lo};
  assign ld_val    = {ctrl_q.wide ? hi_buf : bus_wdata, bus_wdata};
  assign cnt_write = |ld_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_unpack(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_buf <= '0;
    else if (ctrl_q.wide && wr_hi)  hi_buf <= bus_wdata;
    else if (ctrl_q.wide && rd_lo)  hi_buf <= count[CNT_W-1:BUS_W];
  end

  // instruction-cycle divider, phase restarted by any counter write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cyc_q <= '0;
    else if (cnt_write)        cyc_q <= '0;
    else if (cyc_q == DIV_LAST) cyc_q <= '0;
    else                       cyc_q <= cyc_q + DIV_W'(1);
  end
  assign instr_tick = (cyc_q == DIV_LAST);

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_in     (ext_tick_in),
    .bypass     (ctrl_q.raw),
    .edge_pulse (ext_edge)
  );

  assign src_pulse   = ctrl_q.src_ext ? ext_edge : instr_tick;
  assign gated_pulse = src_pulse & ctrl_q.run;

  tmr_prescaler #(.SEL_W(PS_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_pulse  (gated_pulse),
    .sel       (ctrl_q.ps),
    .clr       (cnt_write),
    .out_pulse (step)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (step),
    .clr    (cmp_event),
    .ld_en  (ld_en),
    .ld_val (ld_val),
    .count  (count),
    .wrap   (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap)     ovf_flag <= 1'b1;
    else if (stat_clr) ovf_flag <= 1'b0;
  end
  assign ovf_irq = ovf_flag;

  always_comb begin
    unique case (bus_addr)
      ADR_LO:   bus_rdata = count[BUS_W-1:0];
      ADR_HI:   bus_rdata = ctrl_q.wide ? hi_buf : count[CNT_W-1:BUS_W];
      ADR_CTRL: bus_rdata = ctrl_pack(ctrl_q);
      default:  bus_rdata = {{(BUS_W-1){1'b0}}, ovf_flag};
    endcase
  end

  // R6: with run clear and no write or event, the count cannot move
  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !cmp_event && ld_en == 2'b00) |=> $stable(count));
  // R7: wrap raises the flag, which then persists without a clearing write
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !stat_clr) |=> ovf_flag);
  // R9: a wide low-byte read latches the high half seen in that cycle
  p_buf_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.wide && rd_lo) |=> hi_buf == $past(count[CNT_W-1:BUS_W]));
  // R10: a wide low-byte write loads holding register and data together
  p_wide_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.wide && wr_lo && !cmp_event) |=> count == {$past(hi_buf), $past(bus_wdata)});

endmodule

// File: tb/tmr16_unit_tb.sv
module tmr16_unit_tb;
  import tmr_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr, rd;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ext, evt;
  logic       irq;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #2 clk = ~clk;

  tmr16_unit #(.INSTR_DIV(4), .SYNC_STAGES(2)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (addr),
    .bus_wr      (wr),
    .bus_rd      (rd),
    .bus_wdata   (wdata),
    .bus_rdata   (rdata),
    .ext_tick_in (ext),
    .cmp_event   (evt),
    .ovf_irq     (irq)
  );

  // {ctrl, external?, events or cycles, expected count}
  localparam logic [39:0] VEC [8] = '{
    {8'h81, 1'b0, 15'd40,  16'd10},
    {8'h91, 1'b0, 15'd40,  16'd5},
    {8'hA1, 1'b0, 15'd43,  16'd2},
    {8'hB1, 1'b0, 15'd100, 16'd3},
    {8'h83, 1'b1, 15'd7,   16'd7},
    {8'hA3, 1'b1, 15'd9,   16'd2},
    {8'h97, 1'b1, 15'd5,   16'd2},
    {8'hB7, 1'b1, 15'd16,  16'd2}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(ADR_LO, lo);
    rd_reg(ADR_HI, hi);
    v = {hi, lo};
  endtask

  task automatic pulse();
    ext = 1'b1;
    wait_cyc(2);
    ext = 1'b0;
    wait_cyc(2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    logic [39:0] vec;
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0; ext = 1'b0; evt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    rd_reg(ADR_CTRL, b); check("R1 ctrl", {8'h0, b}, 16'h0);
    rd_reg(ADR_LO, b);   check("R1 lo", {8'h0, b}, 16'h0);
    rd_reg(ADR_HI, b);   check("R1 hi", {8'h0, b}, 16'h0);
    rd_reg(ADR_STAT, b); check("R1 flag", {8'h0, b}, 16'h0);

    // vector table: sources, prescaler ratios, sync and raw paths (R2 R3 R4 R5)
    for (int i = 0; i < 8; i++) begin
      vec = VEC[i];
      wr_reg(ADR_CTRL, vec[39:32]);
      wr_reg(ADR_HI, 8'h00);
      wr_reg(ADR_LO, 8'h00);
      if (vec[31]) begin
        for (int p = 0; p < int'(vec[30:16]); p++) pulse();
        wait_cyc(4);
      end else begin
        wait_cyc(int'(vec[30:16]));
      end
      read16(v);
      check(vec[31] ? (vec[34] ? $sformatf("R5/R3 vec%0d", i) : $sformatf("R4/R3 vec%0d", i))
                    : $sformatf("R2/R3 vec%0d", i), v, vec[15:0]);
    end

    // R11 narrow mode direct access
    wr_reg(ADR_CTRL, 8'h00);
    wr_reg(ADR_HI, 8'h12);
    rd_reg(ADR_HI, b); check("R11 hi direct", {8'h0, b}, 16'h0012);
    wr_reg(ADR_LO, 8'h34);
    rd_reg(ADR_LO, b); check("R11 lo direct", {8'h0, b}, 16'h0034);
    rd_reg(ADR_HI, b); check("R11 hi kept", {8'h0, b}, 16'h0012);

    // R9 holding register is not live
    wr_reg(ADR_CTRL, 8'h80);
    rd_reg(ADR_LO, b); check("R9 lo live", {8'h0, b}, 16'h0034);
    wr_reg(ADR_CTRL, 8'h00);
    wr_reg(ADR_HI, 8'h56);
    wr_reg(ADR_CTRL, 8'h80);
    rd_reg(ADR_HI, b); check("R9 hi buffered", {8'h0, b}, 16'h0012);
    read16(v);         check("R9 fresh pair", v, 16'h5634);

    // R10 wide write buffering
    wr_reg(ADR_HI, 8'hAB);
    read16(v);         check("R10 hi write held back", v, 16'h5634);
    wr_reg(ADR_HI, 8'hAB);
    wr_reg(ADR_LO, 8'hCD);
    wr_reg(ADR_CTRL, 8'h00);
    rd_reg(ADR_HI, b); check("R10 hi loaded", {8'h0, b}, 16'h00AB);
    rd_reg(ADR_LO, b); check("R10 lo loaded", {8'h0, b}, 16'h00CD);

    // R6 run clear holds the count
    wr_reg(ADR_CTRL, 8'h80);
    wr_reg(ADR_HI, 8'h00);
    wr_reg(ADR_LO, 8'h05);
    wait_cyc(40);
    read16(v);         check("R6 hold", v, 16'h0005);

    // R7 overflow flag
    wr_reg(ADR_STAT, 8'h01);
    wr_reg(ADR_CTRL, 8'h81);
    wr_reg(ADR_HI, 8'hFF);
    wr_reg(ADR_LO, 8'hFE);
    wait_cyc(6);
    rd_reg(ADR_STAT, b); check("R7 flag before wrap", {8'h0, b}, 16'h0);
    wait_cyc(2);
    rd_reg(ADR_STAT, b); check("R7 flag after wrap", {8'h0, b}, 16'h1);
    check("R7 irq", {15'h0, irq}, 16'h1);
    wr_reg(ADR_CTRL, 8'h80);
    wait_cyc(10);
    wr_reg(ADR_STAT, 8'h00);
    rd_reg(ADR_STAT, b); check("R7 sticky", {8'h0, b}, 16'h1);
    wr_reg(ADR_STAT, 8'h01);
    rd_reg(ADR_STAT, b); check("R7 cleared", {8'h0, b}, 16'h0);

    // R8 event clear
    wr_reg(ADR_CTRL, 8'h81);
    wr_reg(ADR_HI, 8'h12);
    wr_reg(ADR_LO, 8'h34);
    evt = 1'b1; @(posedge clk); @(negedge clk); evt = 1'b0;
    read16(v);         check("R8 clear", v, 16'h0000);
    wr_reg(ADR_CTRL, 8'h80);
    wr_reg(ADR_HI, 8'h44);
    addr = ADR_LO; wdata = 8'h77; wr = 1'b1; evt = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; evt = 1'b0;
    read16(v);         check("R8 beats write", v, 16'h0000);
    wr_reg(ADR_CTRL, 8'h81);
    wr_reg(ADR_HI, 8'hFF);
    wr_reg(ADR_LO, 8'hFF);
    wait_cyc(3);
    evt = 1'b1; @(posedge clk); @(negedge clk); evt = 1'b0;
    rd_reg(ADR_STAT, b); check("R8 no flag", {8'h0, b}, 16'h0);
    read16(v);         check("R8 beats wrap", v, 16'h0000);

    // R12 write empties the prescaler
    wr_reg(ADR_CTRL, 8'h93);
    wr_reg(ADR_HI, 8'h00);
    wr_reg(ADR_LO, 8'h00);
    pulse();
    wr_reg(ADR_LO, 8'h00);
    pulse();
    wait_cyc(4);
    read16(v);         check("R12 group restarted", v, 16'h0000);
    pulse();
    wait_cyc(4);
    read16(v);         check("R12 group complete", v, 16'h0001);

    // R4 synchronized latency
    wr_reg(ADR_CTRL, 8'h83);
    wr_reg(ADR_HI, 8'h00);
    wr_reg(ADR_LO, 8'h00);
    ext = 1'b1;
    wait_cyc(1);
    rd_reg(ADR_LO, b); check("R4 edge 1", {8'h0, b}, 16'h0);
    rd_reg(ADR_LO, b); check("R4 edge 2", {8'h0, b}, 16'h0);
    rd_reg(ADR_LO, b); check("R4 edge 3", {8'h0, b}, 16'h1);
    ext = 1'b0;
    wait_cyc(4);

    // R5 bypassed latency
    wr_reg(ADR_CTRL, 8'h87);
    wr_reg(ADR_HI, 8'h00);
    wr_reg(ADR_LO, 8'h00);
    ext = 1'b1;
    wait_cyc(1);
    rd_reg(ADR_LO, b); check("R5 edge 1", {8'h0, b}, 16'h1);
    ext = 1'b0;
    wait_cyc(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule